// File: doc/BRIEF.md
# SPE Payload Byte Extractor

This block sits on the byte-wide drop side of a SONET/SDH path terminator that carries either three byte-interleaved STS-1 payload envelopes (STS-3 / STM-1 built from AU3s) or a single STS-1. From three inputs per byte it decides, for every byte, whether that byte is packet data for one of the envelopes: a composite frame-position strobe marking the C1 and J1 positions, a payload-active flag, and the data byte itself. It drives one registered valid enable per envelope together with the registered data byte. A downstream HDLC deframer takes a byte whenever its envelope's enable is high.

A rotating one-hot selector assigns each byte to an envelope. It restarts once per frame at the C1 mark. Each envelope owns a column counter over its 87-byte rows. The counter realigns on that envelope's J1 byte and advances only on that envelope's payload bytes. The path overhead column and both fixed-stuff columns are removed from the enable. Pointer justifications need no special handling. A negative justification adds one payload-active byte, which the counter consumes. A positive justification leaves one byte without the flag, which the counter skips. Setting `NUM_SPE` to 1 removes the selector for a plain STS-1 stream.

Top module: `spe_payload_extract`

## Requirements
- R1: After reset, no envelope claims any byte until the first C1 mark. A C1 mark is the strobe high while the payload flag is low. The byte that follows a C1 mark belongs to envelope #1 (`outValid[0]`). Each later byte belongs to the next envelope, #1 → #2 → #3 → #1, and so on.
- R2: `outValid[s]` is set only for a byte that had the payload flag high and fell in envelope s's slot. At most one bit of `outValid` is high.
- R3: A J1 byte is the strobe high while the payload flag is high. It is column 0 of its envelope and is never reported valid.
- R4: An envelope's column advances only on its own payload-flagged bytes. A byte without the flag (positive justification) is skipped. An extra flagged byte in the H3 position (negative justification) is counted.
- R5: After column 86 the next payload byte of the envelope is column 0. Column 0 (path overhead) is excluded in every row.
- R6: Columns 29 and 58 (the fixed-stuff columns, SPE columns 30 and 59) are excluded.
- R7: The outputs are registered with one cycle of latency. When a bit of `outValid` is high, `outData` equals the byte presented on the previous clock.
- R8: `outValid` is 0 during reset. Each envelope stays silent until its first J1 byte has been seen.
- R9: In a frame without justification, each synchronised envelope reports exactly 756 valid bytes (9 rows of 84).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frameStrobe | input | 1 | Composite C1/J1 position mark (V1 marking disabled) |
| payloadActive | input | 1 | High on bytes inside an envelope |
| dataIn | input | DATA_W | Drop-bus data byte |
| outValid | output | NUM_SPE | Per-envelope packet-byte enable, registered |
| outData | output | DATA_W | Data byte, registered alongside `outValid` |

## Verification
The hardest situation to reach is an envelope whose J1 falls at the very last payload byte of a frame while its neighbours carry justification events in the same row. In that case the silent-until-sync rule, the row wrap and the gap handling all meet. The bench builds full STS-3 frames with a different J1 offset per envelope, one of them at offset 782. It then applies negative and positive justification to different envelopes in the same frame. Every byte is compared against an independent model that keeps a 783-byte index per envelope. A single idle byte between frames makes the selector depend on its per-frame restart.

// File: rtl/spe_extract_pkg.sv
package spe_extract_pkg;
  localparam int MAX_SPE = 3;

  // strobes from the slot control to the column datapath
  typedef struct packed {
    logic [MAX_SPE-1:0] slot;    // one-hot envelope owning the current byte
    logic               payHit;  // current byte lies inside an envelope
    logic               j1Hit;   // current byte is a J1 position
  } slot_ctrl_t;
endpackage

// File: rtl/spe_slot_ctrl.sv
module spe_slot_ctrl
  import spe_extract_pkg::*;
#(
  parameter int NUM_SPE = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frameStrobe,
  input  logic       payloadActive,
  output slot_ctrl_t ctrlOut
);
  logic c1Hit;
  logic [MAX_SPE-1:0] slotFull;

  assign c1Hit = frameStrobe && !payloadActive;

  generate
    if (NUM_SPE == 1) begin : g_single
      // a lone STS-1 owns every byte; no rotation needed
      assign slotFull = MAX_SPE'(1);
    end else begin : g_rotate
      logic [NUM_SPE-1:0] selQ;

      always_ff @(posedge clk) begin
        if (!rst_n)
          selQ <= '0;
        else if (c1Hit)
          selQ <= NUM_SPE'(1);
        else if (selQ != '0)
          selQ <= {selQ[NUM_SPE-2:0], selQ[NUM_SPE-1]};
      end

      assign slotFull = MAX_SPE'(selQ);

      AST_SEL_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(selQ));  // R1
      AST_C1_NEXT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        c1Hit |=> selQ[0]);  // R1
    end
  endgenerate

  assign ctrlOut.slot   = slotFull;
  assign ctrlOut.payHit = payloadActive;
  assign ctrlOut.j1Hit  = frameStrobe && payloadActive;
endmodule

// File: rtl/spe_col_counter.sv
module spe_col_counter #(
  parameter int SPE_COLS    = 87,
  parameter int STUFF_COL_A = 29,
  parameter int STUFF_COL_B = 58
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slotPay,  // payload byte of this envelope
  input  logic slotJ1,   // J1 byte of this envelope
  output logic byteOk    // byte is packet data
);
  localparam int CW = $clog2(SPE_COLS);
  localparam logic [CW-1:0] LAST_COL = CW'(SPE_COLS - 1);

  logic [CW-1:0] nextCol;  // column the next payload byte will take
  logic [CW-1:0] curCol;
  logic          synced;

  assign curCol = slotJ1 ? '0 : nextCol;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nextCol <= '0;
      synced  <= 1'b0;
    end else if (slotJ1) begin
      nextCol <= CW'(1);
      synced  <= 1'b1;
    end else if (slotPay) begin
      nextCol <= (nextCol == LAST_COL) ? '0 : nextCol + 1'b1;
    end
  end

  assign byteOk = slotPay && synced && !slotJ1 &&
                  (curCol != '0) &&
                  (curCol != CW'(STUFF_COL_A)) &&
                  (curCol != CW'(STUFF_COL_B));

  AST_COL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    nextCol <= LAST_COL);  // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !slotPay |=> $stable(nextCol));  // R4
endmodule

// File: rtl/spe_payload_dp.sv
module spe_payload_dp
  import spe_extract_pkg::*;
#(
  parameter int NUM_SPE     = 3,
  parameter int DATA_W      = 8,
  parameter int SPE_COLS    = 87,
  parameter int STUFF_COL_A = 29,
  parameter int STUFF_COL_B = 58
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_ctrl_t        ctrlIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [NUM_SPE-1:0] outValid,
  output logic [DATA_W-1:0] outData
);
  logic [NUM_SPE-1:0] byteOk;

  generate
    for (genvar s = 0; s < NUM_SPE; s++) begin : g_spe
      spe_col_counter #(
        .SPE_COLS   (SPE_COLS),
        .STUFF_COL_A(STUFF_COL_A),
        .STUFF_COL_B(STUFF_COL_B)
      ) u_col (
        .clk    (clk),
        .rst_n  (rst_n),
        .slotPay(ctrlIn.payHit && ctrlIn.slot[s]),
        .slotJ1 (ctrlIn.j1Hit && ctrlIn.slot[s]),
        .byteOk (byteOk[s])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= '0;
      outData  <= '0;
    end else begin
      outValid <= byteOk;
      outData  <= dataIn;
    end
  end
endmodule

// File: rtl/spe_payload_extract.sv
module spe_payload_extract
  import spe_extract_pkg::*;
#(
  parameter int NUM_SPE     = 3,
  parameter int DATA_W      = 8,
  parameter int SPE_COLS    = 87,
  parameter int STUFF_COL_A = 29,
  parameter int STUFF_COL_B = 58
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frameStrobe,
  input  logic               payloadActive,
  input  logic [DATA_W-1:0]  dataIn,
  output logic [NUM_SPE-1:0] outValid,
  output logic [DATA_W-1:0]  outData
);
  slot_ctrl_t ctrlBus;

  spe_slot_ctrl #(.NUM_SPE(NUM_SPE)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .frameStrobe  (frameStrobe),
    .payloadActive(payloadActive),
    .ctrlOut      (ctrlBus)
  );

  spe_payload_dp #(
    .NUM_SPE    (NUM_SPE),
    .DATA_W     (DATA_W),
    .SPE_COLS   (SPE_COLS),
    .STUFF_COL_A(STUFF_COL_A),
    .STUFF_COL_B(STUFF_COL_B)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrlIn  (ctrlBus),
    .dataIn  (dataIn),
    .outValid(outValid),
    .outData (outData)
  );

  AST_VALID_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(outValid));  // R2
  AST_VALID_NEEDS_PAY: assert property (@(posedge clk) disable iff (!rst_n)
    !payloadActive |=> (outValid == '0));  // R2
  AST_J1_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (frameStrobe && payloadActive) |=> (outValid == '0));  // R3
  AST_DATA_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid != '0) |-> (outData == $past(dataIn)));  // R7
endmodule

// File: tb/tb_spe_payload_extract.sv
module tb_spe_payload_extract;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic       frameStrobe;
  logic       payloadActive;
  logic [7:0] dataIn;
  logic [2:0] outValid;
  logic [7:0] outData;

  spe_payload_extract dut (
    .clk(clk), .rst_n(rst_n), .frameStrobe(frameStrobe),
    .payloadActive(payloadActive), .dataIn(dataIn),
    .outValid(outValid), .outData(outData)
  );

  int checks = 0;
  int errors = 0;
  int idx[3];
  bit syn[3];
  bit expV[3];
  string expTag[3];
  logic [7:0] dPrev;
  int validCnt[3];

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // compare outputs against the byte driven one clock earlier
  task automatic cmp_prev();
    for (int s = 0; s < 3; s++) begin
      chk(outValid[s] == expV[s], expTag[s], $sformatf("spe%0d valid", s),
          int'(outValid[s]), int'(expV[s]));
      validCnt[s] += int'(outValid[s]);
    end
    if (expV[0] || expV[1] || expV[2])
      chk(outData == dPrev, "R7", "data", int'(outData), int'(dPrev));
  endtask

  task automatic step(bit strb, bit pa, logic [7:0] d, bit nv[3], string nt[3]);
    @(negedge clk);
    cmp_prev();
    frameStrobe = strb; payloadActive = pa; dataIn = d;
    for (int s = 0; s < 3; s++) begin expV[s] = nv[s]; expTag[s] = nt[s]; end
    dPrev = d;
  endtask

  // one byte of an STS-3 frame; jst codes: 0 none, 1 positive, 2 negative
  task automatic emit(int row, int b, int fr, int jst[3]);
    int s;
    bit pa, strb;
    bit nv[3];
    string nt[3];
    int col;
    s = b % 3;
    for (int k = 0; k < 3; k++) begin nv[k] = 0; nt[k] = "R2"; end
    pa = (b >= 9);
    if (row == 3 && b >= 9 && b < 12 && jst[s] == 1) pa = 0;
    if (row == 3 && b >= 6 && b < 9 && jst[s] == 2) pa = 1;
    strb = (row == 0 && b == 8);
    if (pa) begin
      if (idx[s] == 0) begin
        syn[s] = 1; strb = 1; nt[s] = "R3";
      end else begin
        col = idx[s] % 87;
        if (!syn[s]) nt[s] = "R8";
        else if (col == 0) nt[s] = "R5";
        else if (col == 29 || col == 58) nt[s] = "R6";
        else begin nt[s] = "R4"; nv[s] = 1; end
      end
      idx[s] = (idx[s] + 1) % 783;
    end
    step(strb, pa, 8'((row * 31) + (b * 7) + fr), nv, nt);
  endtask

  task automatic run_frame(int fr, int j0, int j1, int j2);
    int jst[3];
    bit z[3];
    string zt[3];
    jst[0] = j0; jst[1] = j1; jst[2] = j2;
    for (int k = 0; k < 3; k++) begin validCnt[k] = 0; z[k] = 0; zt[k] = "R1"; end
    for (int r = 0; r < 9; r++)
      for (int b = 0; b < 270; b++)
        emit(r, b, fr, jst);
    // idle byte shifts rotation: next frame relies on C1 restart (R1)
    step(0, 0, 8'h00, z, zt);
  endtask

  task automatic t_reset();
    rst_n = 0; frameStrobe = 0; payloadActive = 0; dataIn = 0;
    for (int k = 0; k < 3; k++) begin expV[k] = 0; expTag[k] = "R8"; end
    repeat (3) @(negedge clk);
    chk(outValid == 3'b000, "R8", "valid in reset", int'(outValid), 0);
    rst_n = 1;
  endtask

  task automatic t_no_c1();
    bit z[3];
    string zt[3];
    for (int k = 0; k < 3; k++) begin z[k] = 0; zt[k] = "R1"; end
    for (int i = 0; i < 40; i++) step(0, 1, 8'(i), z, zt);
    step(0, 0, 8'h00, z, zt);
  endtask

  task automatic t_steady();
    idx[0] = 0; idx[1] = 783 - 300; idx[2] = 1;  // J1 offsets 0, 300, 782
    for (int k = 0; k < 3; k++) syn[k] = 0;
    run_frame(1, 0, 0, 0);
    chk(validCnt[0] == 756, "R9", "spe0 first frame count", validCnt[0], 756);
    chk(validCnt[2] == 0, "R8", "spe2 silent before J1", validCnt[2], 0);
    run_frame(2, 0, 0, 0);
    for (int s = 0; s < 3; s++)
      chk(validCnt[s] == 756, "R9", $sformatf("spe%0d steady count", s), validCnt[s], 756);
  endtask

  task automatic t_justify();
    run_frame(3, 2, 1, 0);
    run_frame(4, 0, 0, 0);
    for (int s = 0; s < 3; s++)
      chk(validCnt[s] == 756, "R4", $sformatf("spe%0d after justification", s), validCnt[s], 756);
    run_frame(5, 1, 2, 2);
    chk(validCnt[0] >= 755 && validCnt[0] <= 757, "R4", "spe0 positive frame", validCnt[0], 756);
    run_frame(6, 0, 0, 0);
    for (int s = 0; s < 3; s++)
      chk(validCnt[s] == 756, "R9", $sformatf("spe%0d final count", s), validCnt[s], 756);
  endtask

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_no_c1();
    t_steady();
    t_justify();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule